// File: doc/BRIEF.md
# Multi-Output Programmable Clock Generator

This block derives three auxiliary clocks from a set of source clocks. All source clocks are modelled as single-cycle enable strobes on one reference clock. Each output has its own configuration: a source-select field and a power-of-two prescaler code. Each output emits a clock-enable strobe once per divided period of the source it selects.

Software turns outputs on through a write-one-to-set pulse and off through a write-one-to-clear pulse. It reads the live enable state back on a separate status vector. After it configures and enables an output, it waits for that output's ready bit before using the clock. It can poll the bit, or it can set the matching bit of an interrupt mask so that a ready output raises the shared interrupt line. The mask uses the same set/clear pulse scheme as the enables.

Top module: `auxclk_gen`

## Requirements
- R1: A 1 in `en_set` bit i enables output i and a 1 in `en_clr` bit i disables it, both at the next clock edge. A 0 in either pulse leaves the matching `en_stat` bit unchanged.
- R2: When the same bit is 1 in both `en_set` and `en_clr` in one cycle, the output ends disabled.
- R3: After reset, all outputs are disabled, all mask bits and ready bits are 0, and `irq` is low. Every output is configured with source code 0 (slow clock) and prescaler code 0 (divide by 1).
- R4: `cfg_sel` picks which bit of `src_stb` drives the output. Code 0 is the slow clock (`src_stb[0]`), 1 is the main clock (`src_stb[1]`), 2 is PLL A (`src_stb[2]`) and 3 is PLL B (`src_stb[3]`).
- R5: For prescaler code p in 0..6, an enabled output strobes in the same cycle as every 2^p-th selected source strobe. Code 7 behaves as code 6 (divide by 64).
- R6: A disabled output keeps `clk_stb` low and its count at zero. After it is enabled, its first strobe comes on exactly the 2^p-th selected source strobe seen while enabled.
- R7: A ready bit becomes 1 at the edge that ends the cycle of the output's first strobe after it is enabled or reconfigured. It stays 1 while the output remains enabled and is not reconfigured.
- R8: A configuration write (`cfg_we` bit i) or a disable clears ready bit i at the next edge. A configuration write also suppresses the strobe in its own cycle and restarts the count from zero.
- R9: `irq` is high exactly when some output has both its ready bit and its mask bit set. `irqm_set` and `irqm_clr` act on the mask with the semantics of R1 and R2.
- R10: Setting the enable of an output that is already enabled neither restarts its count nor clears its ready bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_stb | input | 4 | Source clock strobes: slow, main, PLL A, PLL B |
| en_set | input | 3 | Write-one-to-set enable pulse, one bit per output |
| en_clr | input | 3 | Write-one-to-clear enable pulse, one bit per output |
| irqm_set | input | 3 | Write-one-to-set interrupt mask pulse |
| irqm_clr | input | 3 | Write-one-to-clear interrupt mask pulse |
| cfg_we | input | 3 | Configuration write strobe, one bit per output |
| cfg_sel | input | 2 | Source code written on a configuration write |
| cfg_code | input | 3 | Prescaler code written on a configuration write |
| clk_stb | output | 3 | Divided clock-enable strobe per output |
| en_stat | output | 3 | Current enable state per output |
| ready | output | 3 | Ready bit per output |
| irqm_stat | output | 3 | Current interrupt mask |
| irq | output | 1 | Interrupt request |

## Verification
`clk_stb` and `irq` are combinational. They are due in the same cycle as the qualifying source strobe, or in the same cycle as the ready or mask state that produces them. `en_stat`, `irqm_stat`, `ready` and the configuration take effect at the first edge after the pulse. The bench drives every input at the falling edge and samples 1 ns later. At that point it compares all outputs with a behavioural model that it advances once per cycle, in step with the design's rising edge. The directed checks count source strobes and cycles up to the first divided strobe, and read ready and mask state at the falling edge that follows each write.

// File: rtl/auxclk_pkg.sv
package auxclk_pkg;
   // Source codes of the default four-source configuration
   localparam int unsigned SRC_SLOW = 0;
   localparam int unsigned SRC_MAIN = 1;
   localparam int unsigned SRC_PLLA = 2;
   localparam int unsigned SRC_PLLB = 3;

   // Prescaler codes above the largest supported power saturate to it
   function automatic int unsigned clamp_log(input int unsigned code,
                                             input int unsigned max_log);
      return (code > max_log) ? max_log : code;
   endfunction
endpackage

// File: rtl/auxclk_setclr.sv
module auxclk_setclr #(
   parameter int unsigned W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o,
   output logic [W-1:0] nxt_o
);
   logic [W-1:0] q_r;

   // clear has priority over set
   assign nxt_o = (q_r | set_i) & ~clr_i;
   assign q_o   = q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= nxt_o;
   end
endmodule

// File: rtl/auxclk_div.sv
module auxclk_div import auxclk_pkg::*; #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned PRES_W  = 3,
   parameter int unsigned MAX_LOG = 6,
   localparam int unsigned CNT_W  = (MAX_LOG > 0) ? MAX_LOG : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_stb,
   input  logic               en_q,
   input  logic               en_nxt,
   input  logic               cfg_we,
   input  logic [SEL_W-1:0]   cfg_sel,
   input  logic [PRES_W-1:0]  cfg_code,
   output logic               stb_o,
   output logic               ready_o
);
   logic [SEL_W-1:0]  sel_q;
   logic [PRES_W-1:0] code_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  term;
   logic              sel_stb;
   logic              rdy_q;
   int unsigned       eff;

   assign sel_stb = src_stb[sel_q];

   // terminal count: 2^eff - 1 as a thermometer of ones
   always_comb begin
      eff = clamp_log(int'(code_q), MAX_LOG);
      for (int b = 0; b < CNT_W; b++) term[b] = (b < eff);
   end

   assign stb_o   = en_q & sel_stb & ~cfg_we & (cnt_q == term);
   assign ready_o = rdy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         code_q <= '0;
         cnt_q  <= '0;
         rdy_q  <= 1'b0;
      end else begin
         if (cfg_we) begin
            sel_q  <= cfg_sel;
            code_q <= cfg_code;
         end
         if (!en_nxt || cfg_we)     cnt_q <= '0;
         else if (stb_o)            cnt_q <= '0;
         else if (en_q && sel_stb)  cnt_q <= cnt_q + CNT_W'(1);
         if (!en_nxt || cfg_we)     rdy_q <= 1'b0;
         else if (stb_o)            rdy_q <= 1'b1;
      end
   end
endmodule

// File: rtl/auxclk_gen.sv
module auxclk_gen import auxclk_pkg::*; #(
   parameter int unsigned NUM_OUT  = 3,
   parameter int unsigned NUM_SRC  = 4,
   parameter int unsigned PRES_W   = 3,
   parameter int unsigned MAX_LOG  = 6,
   localparam int unsigned SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_stb,
   input  logic [NUM_OUT-1:0] en_set,
   input  logic [NUM_OUT-1:0] en_clr,
   input  logic [NUM_OUT-1:0] irqm_set,
   input  logic [NUM_OUT-1:0] irqm_clr,
   input  logic [NUM_OUT-1:0] cfg_we,
   input  logic [SEL_W-1:0]   cfg_sel,
   input  logic [PRES_W-1:0]  cfg_code,
   output logic [NUM_OUT-1:0] clk_stb,
   output logic [NUM_OUT-1:0] en_stat,
   output logic [NUM_OUT-1:0] ready,
   output logic [NUM_OUT-1:0] irqm_stat,
   output logic               irq
);
   // elaboration-time parameter checks
   if (NUM_SRC < 2 || NUM_SRC != (1 << SEL_W)) begin : g_bad_src
      initial $error("auxclk_gen: NUM_SRC must be a power of two >= 2");
   end
   if (((1 << PRES_W) - 1) < MAX_LOG) begin : g_bad_pres
      initial $error("auxclk_gen: PRES_W too narrow for MAX_LOG");
   end
   if (NUM_OUT < 1) begin : g_bad_out
      initial $error("auxclk_gen: NUM_OUT must be at least 1");
   end

   logic [NUM_OUT-1:0] en_nxt;
   logic [NUM_OUT-1:0] msk_nxt;

   auxclk_setclr #(.W(NUM_OUT)) u_en (
      .clk(clk), .rst_n(rst_n), .set_i(en_set), .clr_i(en_clr),
      .q_o(en_stat), .nxt_o(en_nxt));

   auxclk_setclr #(.W(NUM_OUT)) u_msk (
      .clk(clk), .rst_n(rst_n), .set_i(irqm_set), .clr_i(irqm_clr),
      .q_o(irqm_stat), .nxt_o(msk_nxt));

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      auxclk_div #(
         .NUM_SRC(NUM_SRC), .SEL_W(SEL_W),
         .PRES_W(PRES_W), .MAX_LOG(MAX_LOG)
      ) u_div (
         .clk(clk), .rst_n(rst_n), .src_stb(src_stb),
         .en_q(en_stat[i]), .en_nxt(en_nxt[i]), .cfg_we(cfg_we[i]),
         .cfg_sel(cfg_sel), .cfg_code(cfg_code),
         .stb_o(clk_stb[i]), .ready_o(ready[i]));
   end

   assign irq = |(ready & irqm_stat);

   // mask look-ahead is not needed outside the register
   logic unused_msk;
   assign unused_msk = ^msk_nxt;
endmodule

// File: rtl/auxclk_chk.sv
module auxclk_chk #(
   parameter int unsigned NUM_OUT = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_OUT-1:0] en_set,
   input logic [NUM_OUT-1:0] en_clr,
   input logic [NUM_OUT-1:0] irqm_clr,
   input logic [NUM_OUT-1:0] cfg_we,
   input logic [NUM_OUT-1:0] clk_stb,
   input logic [NUM_OUT-1:0] en_stat,
   input logic [NUM_OUT-1:0] ready,
   input logic [NUM_OUT-1:0] irqm_stat,
   input logic               irq
);
   for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
      assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (en_set[i] && !en_clr[i]) |=> en_stat[i]);
      assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (!en_set[i] && !en_clr[i]) |=> $stable(en_stat[i]));
      assert_clr_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
         en_clr[i] |=> !en_stat[i]);
      assert_quiet_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !en_stat[i] |-> !clk_stb[i]);
      assert_rdy_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (clk_stb[i] && !en_clr[i]) |=> ready[i]);
      assert_rdy_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ready[i] |-> en_stat[i]);
      assert_rdy_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (en_clr[i] || cfg_we[i]) |=> !ready[i]);
      assert_cfg_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_we[i] |-> !clk_stb[i]);
      assert_msk_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
         irqm_clr[i] |=> !irqm_stat[i]);
   end

   assert_irq_nomask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irqm_stat == '0) |-> !irq);
   assert_irq_nordy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ready == '0) |-> !irq);
endmodule

bind auxclk_gen auxclk_chk #(.NUM_OUT(NUM_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
   .irqm_clr(irqm_clr), .cfg_we(cfg_we), .clk_stb(clk_stb),
   .en_stat(en_stat), .ready(ready), .irqm_stat(irqm_stat), .irq(irq));

// File: tb/auxclk_gen_tb.sv
module auxclk_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] src_stb = '0;
   logic [2:0] en_set = '0, en_clr = '0, irqm_set = '0, irqm_clr = '0, cfg_we = '0;
   logic [1:0] cfg_sel = '0;
   logic [2:0] cfg_code = '0;
   logic [2:0] clk_stb, en_stat, ready, irqm_stat;
   logic       irq;

   int total = 0, fails = 0, cyc = 0;
   bit done = 0;
   logic [2:0] last_stb, last_rdy;
   logic [3:0] last_src;

   // behavioural model state
   bit m_en[3], m_rdy[3], m_msk[3];
   int m_cnt[3], m_log[3], m_sel[3];

   always #10 clk = ~clk;   // 50 MHz

   auxclk_gen u_dut (
      .clk(clk), .rst_n(rst_n), .src_stb(src_stb),
      .en_set(en_set), .en_clr(en_clr), .irqm_set(irqm_set), .irqm_clr(irqm_clr),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_code(cfg_code),
      .clk_stb(clk_stb), .en_stat(en_stat), .ready(ready),
      .irqm_stat(irqm_stat), .irq(irq));

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // one clock: drive sources, compare with model, advance model
   task automatic tick();
      bit es[3];
      bit any_irq;
      src_stb = {cyc % 3 == 0, cyc % 2 == 0, 1'b1, cyc % 8 == 0};
      #1;
      any_irq = 0;
      for (int i = 0; i < 3; i++) begin
         es[i] = m_en[i] && src_stb[m_sel[i]] && !cfg_we[i] &&
                 (m_cnt[i] == (1 << m_log[i]) - 1);
         chk("R5 clk_stb", int'(clk_stb[i]), int'(es[i]));
         chk("R1 en_stat", int'(en_stat[i]), int'(m_en[i]));
         chk("R7 ready", int'(ready[i]), int'(m_rdy[i]));
         chk("R9 irqm_stat", int'(irqm_stat[i]), int'(m_msk[i]));
         if (m_rdy[i] && m_msk[i]) any_irq = 1;
      end
      chk("R9 irq", int'(irq), int'(any_irq));
      last_stb = clk_stb; last_rdy = ready; last_src = src_stb;
      for (int i = 0; i < 3; i++) begin
         bit nen;
         nen = (m_en[i] || en_set[i]) && !en_clr[i];
         if (!nen || cfg_we[i])               m_cnt[i] = 0;
         else if (es[i])                      m_cnt[i] = 0;
         else if (m_en[i] && src_stb[m_sel[i]]) m_cnt[i]++;
         if (!nen || cfg_we[i]) m_rdy[i] = 0;
         else if (es[i])        m_rdy[i] = 1;
         if (cfg_we[i]) begin
            m_sel[i] = int'(cfg_sel);
            m_log[i] = (cfg_code > 6) ? 6 : int'(cfg_code);
         end
         m_en[i]  = nen;
         m_msk[i] = (m_msk[i] || irqm_set[i]) && !irqm_clr[i];
      end
      @(negedge clk);
      cyc++;
      en_set = '0; en_clr = '0; irqm_set = '0; irqm_clr = '0; cfg_we = '0;
   endtask

   task automatic run(input int n);
      for (int k = 0; k < n; k++) tick();
   endtask

   // ticks from now up to and including the first strobe of output o
   task automatic cycles_to_stb(input int o, output int n, output int nsrc, input int src);
      n = 0; nsrc = 0;
      for (int k = 0; k < 200; k++) begin
         tick();
         n++;
         if (last_src[src]) nsrc++;
         if (last_stb[o]) break;
      end
   endtask

   initial begin
      int n, ns, slow_seen, out_seen;
      for (int i = 0; i < 3; i++) begin
         m_en[i] = 0; m_rdy[i] = 0; m_msk[i] = 0; m_cnt[i] = 0; m_log[i] = 0; m_sel[i] = 0;
      end
      repeat (3) @(negedge clk);
      chk("R3 reset en_stat", int'(en_stat), 0);
      chk("R3 reset ready", int'(ready), 0);
      chk("R3 reset irqm", int'(irqm_stat), 0);
      chk("R3 reset irq", int'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // default config: slow clock, divide by 1
      en_set = 3'b001; tick();
      slow_seen = 0; out_seen = 0;
      for (int k = 0; k < 24; k++) begin
         tick();
         slow_seen += int'(last_src[0]);
         out_seen  += int'(last_stb[0]);
      end
      chk("R3 default source/divider", out_seen, slow_seen);

      // code 7 saturates at divide by 64 on the main clock
      cfg_we = 3'b001; cfg_sel = 2'd1; cfg_code = 3'd7; tick();
      cycles_to_stb(0, n, ns, 1);
      chk("R5 code 7 period", n, 64);
      chk("R7 ready low at first strobe", int'(last_rdy[0]), 0);
      tick();
      chk("R7 ready after first period", int'(ready[0]), 1);

      // re-enable an enabled output
      en_set = 3'b001; tick();
      chk("R10 ready kept", int'(ready[0]), 1);
      chk("R10 still enabled", int'(en_stat[0]), 1);

      // PLL B, divide by 2, configured while disabled
      cfg_we = 3'b100; cfg_sel = 2'd3; cfg_code = 3'd1; tick();
      chk("R6 disabled no strobe", int'(last_stb[2]), 0);
      en_set = 3'b100; tick();
      cycles_to_stb(2, n, ns, 3);
      chk("R6 first strobe on 2nd PLL B strobe", ns, 2);
      chk("R4 PLL B selected", int'(last_src[3]), 1);
      run(2);
      chk("R7 ready out2", int'(ready[2]), 1);

      // reconfiguration and disable clear ready
      cfg_we = 3'b100; cfg_sel = 2'd3; cfg_code = 3'd1; tick();
      chk("R8 cfg clears ready", int'(ready[2]), 0);
      en_clr = 3'b001; tick();
      chk("R8 disable clears ready", int'(ready[0]), 0);
      out_seen = 0;
      for (int k = 0; k < 10; k++) begin tick(); out_seen += int'(last_stb[0]); end
      chk("R6 disabled output quiet", out_seen, 0);

      // enable set/clear semantics
      cfg_we = 3'b010; cfg_sel = 2'd2; cfg_code = 3'd2; en_set = 3'b010; tick();
      chk("R1 set only out1", int'(en_stat), 3'b110);
      tick();
      chk("R1 zero pulses hold", int'(en_stat), 3'b110);
      en_set = 3'b001; en_clr = 3'b001; tick();
      chk("R2 clear wins", int'(en_stat[0]), 0);

      // interrupt mask
      run(20);
      irqm_set = 3'b010; tick();
      chk("R9 irq with mask and ready", int'(irq), 1);
      irqm_set = 3'b010; irqm_clr = 3'b010; tick();
      chk("R9 mask clear wins", int'(irqm_stat), 0);
      chk("R9 irq off", int'(irq), 0);
      irqm_set = 3'b100; tick();
      chk("R9 irq out2", int'(irq), 1);
      en_clr = 3'b100; tick();
      chk("R9 irq drops with ready", int'(irq), 0);

      // each prescaler code on the main clock
      for (int c = 0; c < 7; c++) begin
         cfg_we = 3'b001; en_set = 3'b001; cfg_sel = 2'd1; cfg_code = 3'(c); tick();
         cycles_to_stb(0, n, ns, 1);
         chk("R5 period by code", n, 1 << c);
      end

      // slow source with divide by 2 on out1
      cfg_we = 3'b010; cfg_sel = 2'd0; cfg_code = 3'd1; tick();
      cycles_to_stb(1, n, ns, 0);
      chk("R4 slow source divide by 2", ns, 2);

      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule